// File: doc/BRIEF.md
# Time-Multiplexed Integrate-and-Fire Neuron

This block is a digital integrate-and-fire neuron bank in which one adder is shared by several neurons. A neuron's fan-in is cut into slices, each slice standing for the column output of one small crossbar. The signed partial sum of each slice arrives as one beat on a valid/ready input that also carries the neuron index, a slot index and a flag marking the beat as the external partial sum from a neighbouring engine. The beats of one timestep are added, one per cycle, into that neuron's membrane potential.

The number of local slices per timestep is set by a configuration input. A second configuration bit adds one external slice after the local ones. Only when the last slice of a timestep has been added does the neuron compare the potential with a signed threshold. It then reports the result on a one-cycle output strobe: the neuron index, the spike bit and the potential left behind. A spike empties the potential. Without a spike the potential stays and keeps growing in the next timestep. A synchronous clear empties every neuron before a new classification.

Top module: `tm_if_neuron`

## Requirements
- R1: After reset, out_valid_o and out_spike_o are 0, and every neuron's potential and slot counter start at zero.
- R2: A local beat (in_ext_i=0) is accepted only when in_slot_i equals the neuron's next expected slot and is no greater than cfg_last_i. Slots are expected from 0 upwards. Any other local beat is dropped and changes nothing.
- R3: Each addition saturates at the signed limits of POT_W bits (2047 and -2048 by default) and never wraps.
- R4: An external beat (in_ext_i=1) is accepted only when cfg_ext_en_i=1 and all cfg_last_i+1 local slots of that neuron have been accepted. It is then the final slice of the timestep. Otherwise it is dropped.
- R5: The threshold is evaluated only on the final slice. One cycle after the final beat is accepted, out_valid_o is 1 for one cycle with out_nrn_o, out_spike_o and out_pot_o. No other beat raises out_valid_o.
- R6: If the saturated potential is greater than or equal to threshold_i (signed), out_spike_o is 1, and the potential is reset to 0 (out_pot_o shows 0).
- R7: If the potential is below threshold, out_spike_o is 0, out_pot_o shows the potential, and that value carries over into the next timestep.
- R8: While clear_i is 1, in_ready_o is 0 and no beat is accepted. The clear zeros every potential and slot counter on the same edge.
- R9: Each neuron keeps its own potential and slot counter, so beats of different neurons may be interleaved.
- R10: With cfg_ext_en_i=0, the local slot cfg_last_i is the final slice, and external beats are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all neurons |
| cfg_last_i | input | SLOT_W | Index of the last local slot (number of local slots minus one) |
| cfg_ext_en_i | input | 1 | Add one external slice after the local ones |
| threshold_i | input | POT_W | Signed firing threshold |
| in_valid_i | input | 1 | Partial-sum beat valid |
| in_ready_o | output | 1 | Beat can be taken |
| in_nrn_i | input | NRN_W | Target neuron index |
| in_slot_i | input | SLOT_W | Local slot index of the beat |
| in_ext_i | input | 1 | Beat is the neighbour's external partial sum |
| in_psum_i | input | PSUM_W | Signed partial sum |
| out_valid_o | output | 1 | Timestep result strobe |
| out_nrn_o | output | NRN_W | Neuron of the result |
| out_spike_o | output | 1 | Spike (1) or none (0) |
| out_pot_o | output | POT_W | Signed potential kept after the timestep |

## Verification
A table of beats drives two neurons in interleaved order with both local and external slices. It separates per-neuron state from shared state, carry-over from reset-after-fire, and the equal-to-threshold case from the just-below case. Out-of-order slots and external beats that arrive early are mixed in with negative sums, so that a dropped beat shows as a changed potential. Directed runs then disable the external slice, push eight maximal sums in each direction to tell saturation from wrap-around, and clear a neuron part-way through a timestep.

// File: rtl/tm_if_neuron.sv
module tm_if_neuron #(
  parameter int NEURONS   = 4,
  parameter int PSUM_W    = 10,
  parameter int POT_W     = 12,
  parameter int MAX_SLOTS = 8,
  localparam int NRN_W  = (NEURONS > 1) ? $clog2(NEURONS) : 1,
  localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic [SLOT_W-1:0]        cfg_last_i,
  input  logic                     cfg_ext_en_i,
  input  logic signed [POT_W-1:0]  threshold_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [NRN_W-1:0]         in_nrn_i,
  input  logic [SLOT_W-1:0]        in_slot_i,
  input  logic                     in_ext_i,
  input  logic signed [PSUM_W-1:0] in_psum_i,
  output logic                     out_valid_o,
  output logic [NRN_W-1:0]         out_nrn_o,
  output logic                     out_spike_o,
  output logic signed [POT_W-1:0]  out_pot_o
);

  localparam logic signed [POT_W-1:0] POT_MAX = {1'b0, {(POT_W-1){1'b1}}};
  localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

  logic signed [POT_W-1:0] pot_q [NEURONS];
  logic [CNT_W-1:0]        cnt_q [NEURONS];

  logic signed [POT_W-1:0] cur_pot;
  logic [CNT_W-1:0]        cur_cnt;
  logic signed [POT_W:0]   wide_sum;
  logic signed [POT_W-1:0] sat_sum;
  logic local_ok, ext_ok, accept, is_final, fire;

  assign in_ready_o = !clear_i;
  assign cur_pot    = pot_q[in_nrn_i];
  assign cur_cnt    = cnt_q[in_nrn_i];

  assign local_ok = !in_ext_i && ({1'b0, in_slot_i} == cur_cnt) && (in_slot_i <= cfg_last_i);
  assign ext_ok   = in_ext_i && cfg_ext_en_i && (cur_cnt == ({1'b0, cfg_last_i} + CNT_W'(1)));
  assign accept   = in_valid_i && in_ready_o && (local_ok || ext_ok);
  assign is_final = ext_ok || (local_ok && !cfg_ext_en_i && (in_slot_i == cfg_last_i));

  assign wide_sum = {cur_pot[POT_W-1], cur_pot}
                  + {{(POT_W+1-PSUM_W){in_psum_i[PSUM_W-1]}}, in_psum_i};

  always_comb begin
    if (wide_sum[POT_W] != wide_sum[POT_W-1])
      sat_sum = wide_sum[POT_W] ? POT_MIN : POT_MAX;
    else
      sat_sum = wide_sum[POT_W-1:0];
  end

  assign fire = sat_sum >= threshold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NEURONS; i++) begin
        pot_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      out_valid_o <= 1'b0;
      out_nrn_o   <= '0;
      out_spike_o <= 1'b0;
      out_pot_o   <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_spike_o <= 1'b0;
      if (clear_i) begin
        for (int i = 0; i < NEURONS; i++) begin
          pot_q[i] <= '0;
          cnt_q[i] <= '0;
        end
      end else if (accept) begin
        if (is_final) begin
          cnt_q[in_nrn_i] <= '0;
          pot_q[in_nrn_i] <= fire ? '0 : sat_sum;
          out_valid_o     <= 1'b1;
          out_nrn_o       <= in_nrn_i;
          out_spike_o     <= fire;
          out_pot_o       <= fire ? '0 : sat_sum;
        end else begin
          cnt_q[in_nrn_i] <= cur_cnt + CNT_W'(1);
          pot_q[in_nrn_i] <= sat_sum;
        end
      end
    end
  end

endmodule

// File: rtl/tm_if_neuron_chk.sv
module tm_if_neuron_chk #(
  parameter int POT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear_i,
  input logic                    cfg_ext_en_i,
  input logic signed [POT_W-1:0] threshold_i,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    in_ext_i,
  input logic                    out_valid_o,
  input logic                    out_spike_o,
  input logic signed [POT_W-1:0] out_pot_o
);

  p_valid_needs_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(in_valid_i && in_ready_o));

  p_spike_only_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> !out_spike_o);

  p_empty_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_spike_o) |-> (out_pot_o == '0));

  p_below_threshold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_spike_o) |-> (out_pot_o < $past(threshold_i)));

  p_clear_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> !out_valid_o);

  p_no_ext_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !$past(cfg_ext_en_i)) |-> !$past(in_ext_i));

endmodule

bind tm_if_neuron tm_if_neuron_chk #(.POT_W(POT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .cfg_ext_en_i(cfg_ext_en_i),
  .threshold_i(threshold_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_ext_i(in_ext_i), .out_valid_o(out_valid_o), .out_spike_o(out_spike_o),
  .out_pot_o(out_pot_o)
);

// File: tb/tm_if_neuron_bench.sv
module tm_if_neuron_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, clear_i, cfg_ext_en_i, in_valid_i, in_ext_i;
  logic [2:0] cfg_last_i, in_slot_i;
  logic signed [11:0] threshold_i;
  logic [1:0] in_nrn_i;
  logic signed [9:0] in_psum_i;
  logic in_ready_o, out_valid_o, out_spike_o;
  logic [1:0] out_nrn_o;
  logic signed [11:0] out_pot_o;

  int checks = 0, errors = 0;
  bit done = 0;

  tm_if_neuron u_tm_if_neuron (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .cfg_last_i(cfg_last_i),
    .cfg_ext_en_i(cfg_ext_en_i), .threshold_i(threshold_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_nrn_i(in_nrn_i), .in_slot_i(in_slot_i),
    .in_ext_i(in_ext_i), .in_psum_i(in_psum_i), .out_valid_o(out_valid_o),
    .out_nrn_o(out_nrn_o), .out_spike_o(out_spike_o), .out_pot_o(out_pot_o)
  );

  // {nrn, slot, ext, psum, exp_valid, exp_spike, exp_pot}; cfg_last=1, ext on, threshold 300
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 10'(100), 1'b0, 1'b0, 12'(0)},
    {2'd0, 3'd1, 1'b0, 10'(50),  1'b0, 1'b0, 12'(0)},
    {2'd0, 3'd0, 1'b1, 10'(40),  1'b1, 1'b0, 12'(190)},
    {2'd1, 3'd0, 1'b0, 10'(200), 1'b0, 1'b0, 12'(0)},
    {2'd0, 3'd0, 1'b0, 10'(60),  1'b0, 1'b0, 12'(0)},
    {2'd1, 3'd1, 1'b0, 10'(150), 1'b0, 1'b0, 12'(0)},
    {2'd1, 3'd0, 1'b1, -10'(10), 1'b1, 1'b1, 12'(0)},
    {2'd0, 3'd1, 1'b0, 10'(30),  1'b0, 1'b0, 12'(0)},
    {2'd0, 3'd0, 1'b1, 10'(20),  1'b1, 1'b1, 12'(0)},
    {2'd2, 3'd1, 1'b0, 10'(99),  1'b0, 1'b0, 12'(0)},
    {2'd2, 3'd0, 1'b1, 10'(5),   1'b0, 1'b0, 12'(0)},
    {2'd2, 3'd0, 1'b0, -10'(50), 1'b0, 1'b0, 12'(0)},
    {2'd2, 3'd1, 1'b0, -10'(20), 1'b0, 1'b0, 12'(0)},
    {2'd2, 3'd0, 1'b1, 10'(0),   1'b1, 1'b0, -12'(70)}
  };

  task automatic check(string req, logic ev, logic es, logic [1:0] en, logic signed [11:0] ep);
    checks++;
    if (out_valid_o !== ev || (ev && (out_spike_o !== es || out_nrn_o !== en || out_pot_o !== ep))
        || (!ev && out_spike_o !== 1'b0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b spike=%0b nrn=%0d pot=%0d, expected valid=%0b spike=%0b nrn=%0d pot=%0d",
               req, out_valid_o, out_spike_o, out_nrn_o, out_pot_o, ev, es, en, ep);
    end
  endtask

  task automatic send(logic [1:0] n, logic [2:0] s, logic e, logic signed [9:0] p);
    in_nrn_i = n; in_slot_i = s; in_ext_i = e; in_psum_i = p; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; clear_i = 0; cfg_ext_en_i = 1; cfg_last_i = 3'd1; threshold_i = 12'(300);
    in_valid_i = 0; in_ext_i = 0; in_slot_i = 0; in_nrn_i = 0; in_psum_i = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", 1'b0, 1'b0, 2'd0, 12'(0));
    checks++;
    if (in_ready_o !== 1'b1) begin errors++; $display("FAIL R1: got ready=%0b expected 1", in_ready_o); end
    rst_n = 1;
    @(negedge clk);

    // Table: R2 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][29:28], VEC[i][27:25], VEC[i][24], VEC[i][23:14]);
      check("R2/R4/R5/R6/R7/R9 table", VEC[i][13], VEC[i][12], VEC[i][29:28], VEC[i][11:0]);
    end

    // R10: ext off, two local slots, last local is final; ext beat dropped
    cfg_ext_en_i = 0; threshold_i = 12'(1000);
    send(2'd3, 3'd0, 1'b0, 10'(100));
    check("R10 first local", 1'b0, 1'b0, 2'd3, 12'(0));
    send(2'd3, 3'd1, 1'b0, 10'(100));
    check("R10 final local", 1'b1, 1'b0, 2'd3, 12'(200));
    send(2'd3, 3'd0, 1'b1, 10'(300));
    check("R10 ext dropped", 1'b0, 1'b0, 2'd3, 12'(0));
    send(2'd3, 3'd0, 1'b0, 10'(1));
    send(2'd3, 3'd1, 1'b0, 10'(1));
    check("R10 ext had no effect", 1'b1, 1'b0, 2'd3, 12'(202));

    // R8: clear mid-timestep
    send(2'd3, 3'd0, 1'b0, 10'(50));
    clear_i = 1;
    #1;
    checks++;
    if (in_ready_o !== 1'b0) begin errors++; $display("FAIL R8: got ready=%0b expected 0", in_ready_o); end
    send(2'd3, 3'd1, 1'b0, 10'(400));
    check("R8 beat during clear", 1'b0, 1'b0, 2'd3, 12'(0));
    clear_i = 0;
    send(2'd3, 3'd0, 1'b0, 10'(5));
    send(2'd3, 3'd1, 1'b0, 10'(6));
    check("R8 potential after clear", 1'b1, 1'b0, 2'd3, 12'(11));

    // R3: saturation, eight slots, ext off
    cfg_last_i = 3'd7; threshold_i = 12'(100);
    for (int s = 0; s < 8; s++) send(2'd1, 3'(s), 1'b0, -10'(512));
    check("R3 negative saturation", 1'b1, 1'b0, 2'd1, -12'(2048));
    clear_i = 1; @(negedge clk); clear_i = 0;
    threshold_i = 12'(2047);
    for (int s = 0; s < 8; s++) send(2'd2, 3'(s), 1'b0, 10'(511));
    check("R3 positive saturation fires", 1'b1, 1'b1, 2'd2, 12'(0));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule